// File: doc/BRIEF.md
# Receive descriptor-chain DMA engine

This block takes received Ethernet frames from a byte-wide stream and stores them into memory buffers that software posts through a chain of descriptors. Each descriptor is 64 bytes long. It holds a buffer address, an ownership flag, a length field, an error code and the address of the next descriptor. The engine follows the chain by that stored pointer rather than by an index, so software may place descriptors anywhere in a 42-bit address space and close the chain into a ring.

For each frame the engine reads the two leading words of the current descriptor and checks the ownership flag. It packs the frame bytes into 64-bit little-endian words and writes them to the buffer. It then writes the error code word, and writes the first word last to hand the slot back. A small register block holds the chain start address, the enable bit, packet and drop counters, and the interrupt cause and mask. Software acknowledges packets one at a time by writing the status register.

Top module: `rxdesc_dma`

## Requirements
- R1: After reset, in_ready, mem_req and irq are 0, and the status register (index 3) and the control register (index 2) read 0.
- R2: While the control register bit 0 is 0, no frame byte is accepted and no memory request is made. Writing 1 to bit 0 arms the engine.
- R3: A frame is handled in the descriptor at the current pointer. The engine reads word 0 at pointer+0 and word 1 at pointer+8. The buffer address is {word1[41:32], word0[31:0]} and the next pointer is {word1[57:48], word1[31:0]}. After a frame is stored, the pointer moves to the next pointer. Writing register 0 (low 32 bits) or register 1 (high 10 bits) reloads the pointer from that pair.
- R4: Frame byte i is stored at buffer address + i in 64-bit little-endian words. Byte lanes after the last byte of the final word are written as 0.
- R5: Write-back order is all buffer words first, then word 2 at pointer+16, then word 0 at pointer+0. Word 1 is never written.
- R6: The written word 0 has bit 63 (the E flag) = 0, bits 43:32 = the stored byte count, bits 31:0 = the buffer address low bits, and all other bits 0.
- R7: Word 2 carries the error code in bits 63:62, with all other bits 0. The codes are 00 for a good frame, 10 when in_err was high on any accepted byte, and 01 when the frame exceeded BUF_BYTES. On truncation only BUF_BYTES bytes are stored. Code 10 takes precedence over 01.
- R8: If word 0 of the current descriptor has E = 0 when a frame starts, the whole frame is consumed with no memory write. Status bits 7:0 (drop count) then increase by 1 and the pointer does not move.
- R9: Status bits 23:16 count stored frames. Writing the status register with bit 0 = 1 lowers the count by one, and the count does not go below 0.
- R10: Interrupt cause bit 4 (register 5) is set for each stored frame, and writing 1 to a cause bit clears it. The mask is register 4. irq equals the OR of cause AND mask, delayed by one clock.
- R11: A memory response with mem_err sets cause bit 7, clears control bit 0 and discards the rest of the frame. No packet is counted and the pointer does not move.
- R12: A memory request holds its address, direction and data until it is acknowledged. Every address is 8-byte aligned, and no request is raised while stream bytes are being accepted.
- R13: Stream bytes arriving between frames without a start marker are discarded up to and including the next end marker, and are not counted as drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_addr |
| irq | output | 1 | Interrupt request |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_err | input | 1 | Upstream error marker for the frame |
| in_ready | output | 1 | Stream byte accepted this cycle when high with in_valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address, 8-byte aligned |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Bus error, valid with mem_ack |

## Verification
The bench builds the engine with BUF_BYTES = 20, so a 25-byte frame exceeds the buffer and the truncation path with a partly filled last word is reached in a few dozen cycles. ADDR_W stays at its default of 42. One descriptor and one buffer are placed above the 32-bit boundary, which exercises the high address fields of word 1 when the chain is followed. The ring has three descriptors closed back on itself, so the ownership check meets a slot already handed back to software.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RD0, S_RD1, S_DATA, S_WRD, S_WR2, S_WR0, S_DROP
  } rx_state_t;

  localparam logic [2:0] REG_BASE_LO = 3'd0;
  localparam logic [2:0] REG_BASE_HI = 3'd1;
  localparam logic [2:0] REG_CTRL    = 3'd2;
  localparam logic [2:0] REG_STAT    = 3'd3;
  localparam logic [2:0] REG_MASK    = 3'd4;
  localparam logic [2:0] REG_CAUSE   = 3'd5;

  localparam int CAUSE_RX   = 4;
  localparam int CAUSE_BERR = 7;
  localparam logic [7:0] CAUSE_BITS = 8'h90;

  localparam logic [1:0] ERR_NONE     = 2'b00;
  localparam logic [1:0] ERR_TRUNC    = 2'b01;
  localparam logic [1:0] ERR_UPSTREAM = 2'b10;

  function automatic logic [1:0] err_code(input logic upstream, input logic cut);
    if (upstream) return ERR_UPSTREAM;
    if (cut) return ERR_TRUNC;
    return ERR_NONE;
  endfunction
endpackage

// File: rtl/rxd_regs.sv
module rxd_regs #(
  parameter int ADDR_W = 42,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              en,
  output logic [ADDR_W-1:0] base_ptr,
  output logic              ptr_load,
  input  logic              ev_pkt,
  input  logic              ev_drop,
  input  logic              ev_berr
);
  import rxd_pkg::*;
  localparam int HI_W = ADDR_W - 32;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [31:0]      base_lo;
  logic [HI_W-1:0]  base_hi;
  logic [7:0]       mask, cause;
  logic [CNT_W-1:0] pkt_cnt, drop_cnt;
  logic             wr_stat, dec, inc;

  assign base_ptr = {base_hi, base_lo};
  assign wr_stat  = reg_wr && (reg_addr == REG_STAT) && reg_wdata[0];
  assign dec      = wr_stat && (pkt_cnt != '0);
  assign inc      = ev_pkt && (pkt_cnt != CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lo   <= '0;
      base_hi   <= '0;
      en        <= 1'b0;
      mask      <= '0;
      cause     <= '0;
      pkt_cnt   <= '0;
      drop_cnt  <= '0;
      irq       <= 1'b0;
      ptr_load  <= 1'b0;
      reg_rdata <= '0;
    end else begin
      ptr_load <= reg_wr && (reg_addr == REG_BASE_LO || reg_addr == REG_BASE_HI);
      if (reg_wr) begin
        case (reg_addr)
          REG_BASE_LO: base_lo <= reg_wdata;
          REG_BASE_HI: base_hi <= reg_wdata[HI_W-1:0];
          REG_CTRL:    en      <= reg_wdata[0];
          REG_MASK:    mask    <= reg_wdata[7:0] & CAUSE_BITS;
          default: ;
        endcase
      end
      if (ev_berr) en <= 1'b0;
      cause <= (cause & ~((reg_wr && reg_addr == REG_CAUSE) ? reg_wdata[7:0] : 8'h00))
             | ({7'd0, ev_berr} << CAUSE_BERR) | ({7'd0, ev_pkt} << CAUSE_RX);
      if (inc && !dec) pkt_cnt <= pkt_cnt + 1'b1;
      else if (dec && !inc) pkt_cnt <= pkt_cnt - 1'b1;
      if (ev_drop && drop_cnt != CNT_MAX) drop_cnt <= drop_cnt + 1'b1;
      irq <= |(cause & mask);
      case (reg_addr)
        REG_BASE_LO: reg_rdata <= base_lo;
        REG_BASE_HI: reg_rdata <= 32'(base_hi);
        REG_CTRL:    reg_rdata <= {31'd0, en};
        REG_STAT:    reg_rdata <= (32'(pkt_cnt) << 16) | 32'(drop_cnt);
        REG_MASK:    reg_rdata <= 32'(mask);
        REG_CAUSE:   reg_rdata <= 32'(cause);
        default:     reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rxd_engine.sv
module rxd_engine #(
  parameter int ADDR_W    = 42,
  parameter int BUF_BYTES = 1536
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] base_ptr,
  input  logic              ptr_load,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_err,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              ev_pkt,
  output logic              ev_drop,
  output logic              ev_berr
);
  import rxd_pkg::*;
  localparam int HI_W  = ADDR_W - 32;
  localparam int LEN_W = 12;
  localparam logic [LEN_W-1:0]  LEN_MAX = LEN_W'(BUF_BYTES);
  localparam logic [ADDR_W-1:0] OFS_W1  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_W2  = ADDR_W'(16);

  rx_state_t         state;
  logic [ADDR_W-1:0] cur_ptr, nxt_ptr, buf_ptr;
  logic [31:0]       w0_lo;
  logic              e_ok, eop_seen, cut, uerr;
  logic [LEN_W-1:0]  len;
  logic [3:0]        fill;
  logic [63:0]       wbuf, wbuf_nx;
  logic              store, full_nx, pend_nx, uerr_nx, cut_nx;
  logic              rd_unused;

  assign rd_unused = ^mem_rdata[63:32];
  assign in_ready  = (state == S_DATA) || (state == S_DROP);

  always_comb begin
    store   = (len < LEN_MAX);
    wbuf_nx = wbuf;
    if (store) wbuf_nx[{fill[2:0], 3'b000} +: 8] = in_data;
    full_nx = store && (fill == 4'd7);
    pend_nx = store || (fill != 4'd0);
    uerr_nx = uerr | in_err;
    cut_nx  = cut | !store;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cur_ptr <= '0; nxt_ptr <= '0; buf_ptr <= '0; w0_lo <= '0;
      e_ok <= 1'b0; eop_seen <= 1'b0; cut <= 1'b0; uerr <= 1'b0;
      len <= '0; fill <= '0; wbuf <= '0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      ev_pkt <= 1'b0; ev_drop <= 1'b0; ev_berr <= 1'b0;
    end else begin
      ev_pkt <= 1'b0; ev_drop <= 1'b0; ev_berr <= 1'b0;
      if (mem_req && mem_ack && mem_err) begin
        mem_req <= 1'b0;
        ev_berr <= 1'b1;
        state   <= eop_seen ? S_IDLE : S_DROP;
      end else begin
        case (state)
          S_IDLE: begin
            if (ptr_load) cur_ptr <= base_ptr;
            len <= '0; fill <= '0; wbuf <= '0;
            eop_seen <= 1'b0; cut <= 1'b0; uerr <= 1'b0;
            if (en && in_valid && !ptr_load) begin
              if (in_sop) begin
                state <= S_RD0; mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= cur_ptr;
              end else begin
                state <= S_DROP;
              end
            end
          end
          S_RD0: if (mem_ack) begin
            w0_lo    <= mem_rdata[31:0];
            e_ok     <= mem_rdata[63];
            mem_addr <= cur_ptr + OFS_W1;
            state    <= S_RD1;
          end
          S_RD1: if (mem_ack) begin
            mem_req <= 1'b0;
            if (!e_ok) begin
              ev_drop <= 1'b1;
              state   <= S_DROP;
            end else begin
              buf_ptr <= {mem_rdata[32 +: HI_W], w0_lo};
              nxt_ptr <= {mem_rdata[48 +: HI_W], mem_rdata[31:0]};
              state   <= S_DATA;
            end
          end
          S_DATA: if (in_valid) begin
            uerr <= uerr_nx;
            cut  <= cut_nx;
            wbuf <= wbuf_nx;
            if (store) begin
              len  <= len + 1'b1;
              fill <= fill + 1'b1;
            end
            if (in_eop) eop_seen <= 1'b1;
            if ((in_eop && pend_nx) || full_nx) begin
              state <= S_WRD; mem_req <= 1'b1; mem_we <= 1'b1;
              mem_addr <= buf_ptr; mem_wdata <= wbuf_nx;
            end else if (in_eop) begin
              state <= S_WR2; mem_req <= 1'b1; mem_we <= 1'b1;
              mem_addr <= cur_ptr + OFS_W2; mem_wdata <= {err_code(uerr_nx, cut_nx), 62'd0};
            end
          end
          S_WRD: if (mem_ack) begin
            buf_ptr <= buf_ptr + OFS_W1;
            fill    <= '0;
            wbuf    <= '0;
            if (eop_seen) begin
              state <= S_WR2; mem_addr <= cur_ptr + OFS_W2;
              mem_wdata <= {err_code(uerr, cut), 62'd0};
            end else begin
              state <= S_DATA; mem_req <= 1'b0;
            end
          end
          S_WR2: if (mem_ack) begin
            state <= S_WR0; mem_addr <= cur_ptr;
            mem_wdata <= {1'b0, 19'd0, len, w0_lo};
          end
          S_WR0: if (mem_ack) begin
            mem_req <= 1'b0;
            cur_ptr <= nxt_ptr;
            ev_pkt  <= 1'b1;
            state   <= S_IDLE;
          end
          S_DROP: if (in_valid && in_eop) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxdesc_dma.sv
module rxdesc_dma #(
  parameter int ADDR_W    = 42,
  parameter int BUF_BYTES = 1536,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_err,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err
);
  logic              en, ptr_load, ev_pkt, ev_drop, ev_berr;
  logic [ADDR_W-1:0] base_ptr;

  rxd_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .en(en),
    .base_ptr(base_ptr), .ptr_load(ptr_load),
    .ev_pkt(ev_pkt), .ev_drop(ev_drop), .ev_berr(ev_berr)
  );

  rxd_engine #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)) u_eng (
    .clk(clk), .rst(rst), .en(en), .base_ptr(base_ptr), .ptr_load(ptr_load),
    .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .in_err(in_err), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .ev_pkt(ev_pkt), .ev_drop(ev_drop), .ev_berr(ev_berr)
  );
endmodule

// File: rtl/rxd_checker.sv
module rxd_checker #(
  parameter int ADDR_W    = 42,
  parameter int BUF_BYTES = 1536
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [63:0]       mem_wdata,
  input logic              mem_ack,
  input rxd_pkg::rx_state_t st
);
  import rxd_pkg::*;

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_req && !in_ready));

  a_r12_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r12_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[2:0] == 3'b000));

  a_r12_stream_no_mem: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !mem_req);

  a_r6_word0_fields: assert property (@(posedge clk) disable iff (rst)
    (st == S_WR0 && mem_req) |-> (mem_we && !mem_wdata[63] && mem_wdata[43:32] != 12'd0
                                  && mem_wdata[43:32] <= 12'(BUF_BYTES)));

  a_r5_word0_after_word2: assert property (@(posedge clk) disable iff (rst)
    (st == S_WR0) |-> ($past(st) == S_WR0 || $past(st) == S_WR2));
endmodule

bind rxdesc_dma rxd_checker #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .st(u_eng.state)
);

// File: tb/rxdesc_dma_tb_top.sv
`timescale 1ns/1ps
module rxdesc_dma_tb_top;
  localparam int AW  = 42;
  localparam int BUF = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          reg_wr = 0;
  logic [2:0]    reg_addr = 0;
  logic [31:0]   reg_wdata = 0, reg_rdata;
  logic          irq;
  logic          in_valid = 0, in_sop = 0, in_eop = 0, in_err = 0, in_ready;
  logic [7:0]    in_data = 0;
  logic          mem_req, mem_we, mem_ack, mem_err;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata, mem_rdata;

  rxdesc_dma #(.ADDR_W(AW), .BUF_BYTES(BUF)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err)
  );

  // memory model
  logic [63:0]   mem [bit [38:0]];
  logic [AW-1:0] wlog [0:511];
  int            wn = 0, rn = 0, misal = 0;
  int            berr_at = -1;
  logic          poke_en = 0;
  logic [AW-1:0] poke_a = 0;
  logic [63:0]   poke_d = 0;

  function automatic logic [63:0] rd(input logic [AW-1:0] a);
    if (mem.exists(a[AW-1:3])) return mem[a[AW-1:3]];
    return 64'd0;
  endfunction

  always @(posedge clk) begin
    if (poke_en) mem[poke_a[AW-1:3]] = poke_d;
    if (rst) begin
      mem_ack <= 0; mem_err <= 0; mem_rdata <= 0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1;
      if (mem_addr[2:0] != 0) misal <= misal + 1;
      if (mem_we) begin
        mem_err <= (wn == berr_at);
        if (wn != berr_at) mem[mem_addr[AW-1:3]] = mem_wdata;
        if (wn < 512) wlog[wn] <= mem_addr;
        wn <= wn + 1;
      end else begin
        mem_err <= 0;
        mem_rdata <= rd(mem_addr);
        rn <= rn + 1;
      end
    end else begin
      mem_ack <= 0; mem_err <= 0;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic poke(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk); poke_en = 1; poke_a = a; poke_d = d;
    @(negedge clk); poke_en = 0;
  endtask

  task automatic post(input logic [AW-1:0] d, input logic [AW-1:0] b, input logic [AW-1:0] n);
    poke(d, {1'b1, 19'd0, 12'd0, b[31:0]});
    poke(d + 8, {6'd0, n[41:32], 6'd0, b[41:32], n[31:0]});
    poke(d + 16, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic send(input int n, input logic [7:0] pat, input bit err_last, input bit nosop);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = pat + 8'(i);
      in_sop = (i == 0) && !nosop; in_eop = (i == n - 1); in_err = err_last && (i == n - 1);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0; in_err = 0;
    repeat (30) @(negedge clk);
  endtask

  task automatic chk_buf(input string tag, input logic [AW-1:0] b, input int n, input logic [7:0] pat);
    for (int w = 0; w < (n + 7) / 8; w++) begin
      logic [63:0] e;
      e = 0;
      for (int j = 0; j < 8; j++)
        if (w * 8 + j < n) e[j*8 +: 8] = pat + 8'(w * 8 + j);
      chk(tag, rd(b + AW'(w * 8)), e);
    end
  endtask

  localparam logic [AW-1:0] D0 = 42'h0_0000_1000, B0 = 42'h0_0000_2000;
  localparam logic [AW-1:0] D1 = 42'h0_0000_1040, B1 = {10'h001, 32'h0000_3000};
  localparam logic [AW-1:0] D2 = {10'h002, 32'h0000_1080}, B2 = 42'h0_0000_4000;
  logic [31:0] r;

  task automatic t_reset();
    chk("R1 in_ready", in_ready, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 irq", irq, 0);
    reg_read(3'd3, r); chk("R1 status", r, 0);
    reg_read(3'd2, r); chk("R1 ctrl", r, 0);
  endtask

  task automatic t_disabled();
    @(negedge clk); in_valid = 1; in_sop = 1; in_data = 8'hAA;
    repeat (10) @(negedge clk);
    chk("R2 ready while disabled", in_ready, 0);
    chk("R2 no memory request", 64'(rn + wn), 0);
    in_valid = 0; in_sop = 0;
    reg_write(3'd2, 1);
    reg_read(3'd2, r); chk("R2 enabled", r, 1);
  endtask

  task automatic t_good();
    int w0;
    w0 = wn;
    send(11, 8'h10, 0, 0);
    chk("R5 write count", 64'(wn - w0), 4);
    chk("R5 word2 before word0", wlog[w0 + 2], D0 + 16);
    chk("R5 word0 last", wlog[w0 + 3], D0);
    chk("R4 first word addr", wlog[w0], B0);
    chk_buf("R4 buffer", B0, 11, 8'h10);
    chk("R7 code good", rd(D0 + 16), 64'd0);
    chk("R6 word0", rd(D0), {1'b0, 19'd0, 12'd11, 32'h2000});
    chk("R5 word1 kept", rd(D0 + 8), {6'd0, D1[41:32], 6'd0, B0[41:32], D1[31:0]});
    reg_read(3'd3, r); chk("R9 count 1", r, 32'h0001_0000);
    reg_read(3'd5, r); chk("R10 cause rx", r, 32'h10);
    chk("R10 irq", irq, 1);
  endtask

  task automatic t_err();
    send(5, 8'h40, 1, 0);
    chk_buf("R3 high buffer", B1, 5, 8'h40);
    chk("R7 code upstream", rd(D1 + 16), {2'b10, 62'd0});
    chk("R3 word0 of second desc", rd(D1), {1'b0, 19'd0, 12'd5, 32'h3000});
  endtask

  task automatic t_trunc();
    poke(B2 + 24, 64'hFEED_FACE_CAFE_BEEF);
    send(25, 8'h80, 0, 0);
    chk_buf("R7 truncated buffer", B2, BUF, 8'h80);
    chk("R7 past buffer untouched", rd(B2 + 24), 64'hFEED_FACE_CAFE_BEEF);
    chk("R7 code trunc", rd(D2 + 16), {2'b01, 62'd0});
    chk("R7 size", rd(D2), {1'b0, 19'd0, 12'(BUF), 32'h4000});
    reg_read(3'd3, r); chk("R9 count 3", r, 32'h0003_0000);
  endtask

  task automatic t_ack();
    for (int k = 0; k < 4; k++) begin
      reg_write(3'd3, 1);
      reg_read(3'd3, r);
      chk("R9 decrement", r, 32'((k < 3 ? 2 - k : 0)) << 16);
    end
    reg_write(3'd5, 32'h10);
    reg_read(3'd5, r); chk("R10 cause cleared", r, 0);
    @(negedge clk); chk("R10 irq low", irq, 0);
  endtask

  task automatic t_drop();
    int w0;
    w0 = wn;
    send(6, 8'h55, 0, 0);
    chk("R8 no writes", 64'(wn - w0), 0);
    reg_read(3'd3, r); chk("R8 drop count", r, 32'h0000_0001);
    post(D0, B0, D1);
    send(3, 8'hC0, 0, 0);
    chk("R8 pointer held", rd(D0), {1'b0, 19'd0, 12'd3, 32'h2000});
    chk_buf("R8 buffer", B0, 3, 8'hC0);
  endtask

  task automatic t_junk();
    post(D1, B1, D2);
    send(4, 8'h33, 0, 1);
    send(9, 8'h60, 0, 0);
    chk("R13 frame size", rd(D1), {1'b0, 19'd0, 12'd9, 32'h3000});
    chk_buf("R13 frame data", B1, 9, 8'h60);
    reg_read(3'd3, r); chk("R13 drops unchanged", r, 32'h0002_0001);
  endtask

  task automatic t_berr();
    post(D2, B2, D0);
    reg_write(3'd5, 32'hFF);
    berr_at = wn;
    send(10, 8'h70, 0, 0);
    reg_read(3'd5, r); chk("R11 cause berr", r, 32'h80);
    reg_read(3'd2, r); chk("R11 disabled", r, 0);
    reg_read(3'd3, r); chk("R11 no count", r, 32'h0002_0001);
    chk("R11 irq", irq, 1);
    chk("R11 desc untouched", rd(D2), {1'b1, 19'd0, 12'd0, 32'h4000});
    reg_write(3'd5, 32'h80);
    reg_write(3'd2, 1);
    send(4, 8'h90, 0, 0);
    chk("R11 same desc reused", rd(D2), {1'b0, 19'd0, 12'd4, 32'h4000});
    chk_buf("R11 data", B2, 4, 8'h90);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    post(D0, B0, D1); post(D1, B1, D2); post(D2, B2, D0);
    reg_write(3'd1, 0);
    reg_write(3'd0, 32'h1000);
    reg_write(3'd4, 32'h90);
    t_disabled();
    t_good();
    t_err();
    t_trunc();
    t_ack();
    t_drop();
    t_junk();
    t_berr();
    chk("R12 aligned addresses", 64'(misal), 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule